// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns a small set of external interrupt pins into interrupt requests for a CPU sequencer. Each pin goes through a synchroniser. A previous-sample register then compares consecutive synchronised values. A two-bit sense field per input picks one of three trigger modes, and a fourth encoding is reserved. The modes are a low level, a falling edge and a rising edge.

Edge events are stored in a pending flag. The flag stays set until the sequencer acknowledges that input or software writes a one to its bit. A low-level request is not stored. It follows the synchronised pin and lasts exactly as long as the pin stays low. The block sees only the pin value, so software can raise an interrupt by driving the pin itself.

A request reaches the CPU only when the global enable is on and the input's mask bit is set. When more than one input qualifies, the lowest-numbered input wins.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset with the pins idle high, `pend_o` is all zeros and `irq_o` is low.
- R2: Sense code 2'b00 (low level): `pend_o[k]` is high two clock edges after the pin goes low and stays high while the pin stays low. Acknowledge and write-one-to-clear have no effect on it. It drops two edges after the pin returns high.
- R3: Sense code 2'b10 (falling edge): a high-to-low pin change sets the flag, which is visible on `pend_o[k]` three clock edges after the change. The flag stays set after the pin returns high.
- R4: Sense code 2'b11 (rising edge): a low-to-high pin change sets the flag with the same three-edge latency. A high-to-low change does not set it.
- R5: Sense code 2'b01 is reserved: neither pin level nor pin edges produce any pending state.
- R6: `ack_i[k]` clears the edge flag of input k only. Other flags are unchanged.
- R7: With `clr_wr_i` high, each one in `clr_data_i` clears the matching edge flag, and each zero leaves its flag unchanged.
- R8: When a flag is set and cleared in the same cycle, the set wins.
- R9: `irq_o` is high exactly when `gie_i` is high and at least one input has both `pend_o` and `mask_i` set.
- R10: While `irq_o` is high, `irq_id_o` gives the lowest index whose pending and mask bits are both set (field k of `sense_cfg_i` is bits 2k+1:2k).
- R11: The previous-sample register updates in every mode. If a transition reaches the detection stage in the same cycle the field switches into an edge mode, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_IN | Raw pin levels, asynchronous |
| sense_cfg_i | input | 2*NUM_IN | Sense fields, input k at bits 2k+1:2k |
| mask_i | input | NUM_IN | Per-input request mask |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_IN | Sequencer acknowledge, clears edge flag |
| clr_wr_i | input | 1 | Write strobe for the pending status |
| clr_data_i | input | NUM_IN | Write data, ones clear flags |
| pend_o | output | NUM_IN | Pending status per input |
| irq_o | output | 1 | Request to the CPU sequencer |
| irq_id_o | output | IDW | Index of the winning input |

## Verification
The bench measures the latency of the level and edge paths separately. A missing or extra synchroniser stage would move the first cycle the request is seen. It holds a pin low in level mode while acknowledging and clearing, to catch a design that latches level requests or lets them be cleared. It lines up a clear with a new edge in the same cycle, where a clear-wins design would lose the event. It also switches a field into edge mode exactly as a stale transition reaches detection, which exposes a design that gates the previous-sample register by mode. Constrained random traffic is compared against a cycle model, with both inputs active to stress priority and per-input acknowledge.

// File: rtl/eis_pkg.sv
package eis_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_RSVD = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   function automatic int unsigned id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= {WIDTH{RST_VAL}};
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/eis_detect.sv
module eis_detect
   import eis_pkg::*;
#(
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   smp_i,
   input  sense_e mode_i,
   input  logic   clr_i,
   output logic   pend_o
);

   logic prev_q;
   logic flag_q;
   logic rise, fall, set_edge, level_req;

   always_comb begin
      rise      = !prev_q &&  smp_i;
      fall      =  prev_q && !smp_i;
      set_edge  = ((mode_i == SENSE_FALL) && fall) ||
                  ((mode_i == SENSE_RISE) && rise);
      level_req = (mode_i == SENSE_LOW) && !smp_i;
   end

   // prev_q follows the sample in every mode, so a mode switch can see a stale transition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= IDLE_VAL;
         flag_q <= 1'b0;
      end else begin
         prev_q <= smp_i;
         flag_q <= set_edge || (flag_q && !clr_i);
      end
   end

   assign pend_o = flag_q || level_req;

endmodule

// File: rtl/eis_arbiter.sv
module eis_arbiter #(
   parameter int unsigned NUM_IN = 2,
   parameter int unsigned IDW    = 1
) (
   input  logic [NUM_IN-1:0] req_i,
   input  logic              gie_i,
   output logic              irq_o,
   output logic [IDW-1:0]    id_o
);

   always_comb begin
      id_o = '0;
      for (int k = int'(NUM_IN) - 1; k >= 0; k--) begin
         if (req_i[k]) id_o = IDW'(k);
      end
      irq_o = gie_i && (req_i != '0);
   end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import eis_pkg::*;
#(
   parameter int unsigned NUM_IN      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PIN_IDLE    = 1'b1,
   localparam int unsigned IDW        = id_width(NUM_IN),
   localparam int unsigned CFGW       = 2 * NUM_IN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] pin_i,
   input  logic [CFGW-1:0]   sense_cfg_i,
   input  logic [NUM_IN-1:0] mask_i,
   input  logic              gie_i,
   input  logic [NUM_IN-1:0] ack_i,
   input  logic              clr_wr_i,
   input  logic [NUM_IN-1:0] clr_data_i,
   output logic [NUM_IN-1:0] pend_o,
   output logic              irq_o,
   output logic [IDW-1:0]    irq_id_o
);

   if (NUM_IN < 1) begin : g_bad_num
      $error("ext_irq_sense: NUM_IN must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_sense: SYNC_STAGES must be at least 2");
   end

   logic [NUM_IN-1:0] pin_s;
   logic [NUM_IN-1:0] clr_vec;

   eis_sync #(
      .WIDTH  (NUM_IN),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_i),
      .q_o  (pin_s)
   );

   assign clr_vec = ack_i | (clr_data_i & {NUM_IN{clr_wr_i}});

   for (genvar k = 0; k < int'(NUM_IN); k++) begin : g_in
      eis_detect #(
         .IDLE_VAL(PIN_IDLE)
      ) u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .smp_i (pin_s[k]),
         .mode_i(sense_e'(sense_cfg_i[2*k +: 2])),
         .clr_i (clr_vec[k]),
         .pend_o(pend_o[k])
      );
   end

   eis_arbiter #(
      .NUM_IN(NUM_IN),
      .IDW   (IDW)
   ) u_arb (
      .req_i(pend_o & mask_i),
      .gie_i(gie_i),
      .irq_o(irq_o),
      .id_o (irq_id_o)
   );

endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
   parameter int unsigned NUM_IN = 2,
   parameter int unsigned IDW    = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2*NUM_IN-1:0] sense_cfg_i,
   input logic [NUM_IN-1:0]   mask_i,
   input logic                gie_i,
   input logic [NUM_IN-1:0]   pend_o,
   input logic                irq_o,
   input logic [IDW-1:0]      irq_id_o
);

   logic [NUM_IN-1:0] below_win;
   always_comb below_win = (NUM_IN'(1) << irq_id_o) - NUM_IN'(1);

   a_r9_gie_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> !irq_o);

   a_r9_winner_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend_o[irq_id_o] && mask_i[irq_id_o]));

   a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((pend_o & mask_i & below_win) == '0));

   for (genvar k = 0; k < int'(NUM_IN); k++) begin : g_k
      a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
         ((sense_cfg_i[2*k +: 2] == 2'b01) && ($past(sense_cfg_i[2*k +: 2]) == 2'b01)
          && !$past(pend_o[k])) |-> !pend_o[k]);
   end

endmodule

bind ext_irq_sense eis_checker #(
   .NUM_IN(NUM_IN),
   .IDW   (IDW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sense_cfg_i(sense_cfg_i),
   .mask_i     (mask_i),
   .gie_i      (gie_i),
   .pend_o     (pend_o),
   .irq_o      (irq_o),
   .irq_id_o   (irq_id_o)
);

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;

   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin = '1;
   logic [2*N-1:0] cfg = '0;
   logic [N-1:0] mask = '0;
   logic         gie = 1'b0;
   logic [N-1:0] ack = '0;
   logic         clr_wr = 1'b0;
   logic [N-1:0] clr_data = '0;
   logic [N-1:0] pend;
   logic         irq;
   logic [0:0]   irq_id;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string tag = "R1";

   logic [N-1:0] m_st1 = '1, m_st2 = '1, m_prev = '1, m_flag = '0;

   always #10 clk = ~clk;

   ext_irq_sense dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_cfg_i(cfg),
      .mask_i(mask), .gie_i(gie), .ack_i(ack), .clr_wr_i(clr_wr),
      .clr_data_i(clr_data), .pend_o(pend), .irq_o(irq), .irq_id_o(irq_id)
   );

   function automatic logic [N-1:0] exp_pend();
      logic [N-1:0] r;
      for (int k = 0; k < N; k++)
         r[k] = m_flag[k] | ((cfg[2*k +: 2] == 2'b00) & ~m_st2[k]);
      return r;
   endfunction

   function automatic logic exp_irq();
      return gie && ((exp_pend() & mask) != '0);
   endfunction

   function automatic int exp_id();
      logic [N-1:0] q = exp_pend() & mask;
      for (int k = 0; k < N; k++) if (q[k]) return k;
      return 0;
   endfunction

   task automatic chk(input string t, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk({tag, " pend"}, int'(pend), int'(exp_pend()));
      chk("R9 irq", int'(irq), int'(exp_irq()));
      if (exp_irq()) chk("R10 id", int'(irq_id), exp_id());
   endtask

   task automatic model_step();
      logic [N-1:0] nf;
      for (int k = 0; k < N; k++) begin
         logic st, cl;
         st = ((cfg[2*k +: 2] == 2'b10) &  m_prev[k] & ~m_st2[k]) |
              ((cfg[2*k +: 2] == 2'b11) & ~m_prev[k] &  m_st2[k]);
         cl = ack[k] | (clr_wr & clr_data[k]);
         nf[k] = st | (m_flag[k] & ~cl);
      end
      m_flag = nf;
      m_prev = m_st2;
      m_st2  = m_st1;
      m_st1  = pin;
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         model_step();
         @(negedge clk);
         check_all();
      end
   endtask

   task automatic expect_pend(input string t, input int k, input logic v);
      chk(t, int'(pend[k]), int'(v));
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      check_all();
      expect_pend("R1 reset pend", 0, 1'b0);
      chk("R1 reset irq", int'(irq), 0);

      gie = 1; mask = '1; cfg = 4'b0000;
      // R2 level mode
      tag = "R2";
      pin[0] = 0;
      tick(1); expect_pend("R2 not yet", 0, 1'b0);
      tick(1); expect_pend("R2 level seen", 0, 1'b1);
      ack = 2'b01; clr_wr = 1; clr_data = 2'b01;
      tick(1);
      ack = '0; clr_wr = 0; clr_data = '0;
      tick(1); expect_pend("R2 not clearable", 0, 1'b1);
      pin[0] = 1;
      tick(1); expect_pend("R2 still low", 0, 1'b1);
      tick(1); expect_pend("R2 released", 0, 1'b0);

      // R3 falling edge
      tag = "R3";
      cfg[1:0] = 2'b10;
      tick(2);
      pin[0] = 0;
      tick(2); expect_pend("R3 before latency", 0, 1'b0);
      tick(1); expect_pend("R3 edge latched", 0, 1'b1);
      pin[0] = 1;
      tick(4); expect_pend("R3 flag held", 0, 1'b1);

      // R4 rising edge
      tag = "R4";
      cfg[3:2] = 2'b11;
      tick(1);
      pin[1] = 0;
      tick(4); expect_pend("R4 fall ignored", 1, 1'b0);
      pin[1] = 1;
      tick(2); expect_pend("R4 before latency", 1, 1'b0);
      tick(1); expect_pend("R4 edge latched", 1, 1'b1);
      chk("R10 both pending id", int'(irq_id), 0);

      // R6 acknowledge
      tag = "R6";
      ack = 2'b01; tick(1); ack = '0;
      expect_pend("R6 acked cleared", 0, 1'b0);
      expect_pend("R6 other kept", 1, 1'b1);
      chk("R10 remaining id", int'(irq_id), 1);

      // R7 write one to clear
      tag = "R7";
      clr_wr = 1; clr_data = 2'b00; tick(1);
      expect_pend("R7 zero keeps", 1, 1'b1);
      clr_data = 2'b10; tick(1);
      clr_wr = 0; clr_data = '0;
      expect_pend("R7 one clears", 1, 1'b0);

      // R9 gating
      tag = "R9";
      pin[1] = 0; tick(4); pin[1] = 1; tick(3);
      gie = 0; tick(1); chk("R9 gie off", int'(irq), 0);
      gie = 1; mask = 2'b01; tick(1); chk("R9 masked", int'(irq), 0);
      mask = '1; tick(1); chk("R9 enabled", int'(irq), 1);
      clr_wr = 1; clr_data = '1; tick(1); clr_wr = 0; clr_data = '0;

      // R8 set beats clear
      tag = "R8";
      pin[1] = 0; tick(4);
      pin[1] = 1; tick(2);
      ack = 2'b10; tick(1); ack = '0;
      expect_pend("R8 set wins", 1, 1'b1);
      ack = 2'b10; tick(1); ack = '0;

      // R5 reserved
      tag = "R5";
      cfg[1:0] = 2'b01;
      tick(2);
      pin[0] = 0; tick(4); expect_pend("R5 low silent", 0, 1'b0);
      pin[0] = 1; tick(4); expect_pend("R5 edges silent", 0, 1'b0);

      // R11 mode switch meets stale transition
      tag = "R11";
      pin[0] = 0; tick(2);
      cfg[1:0] = 2'b10; tick(1);
      expect_pend("R11 spurious set", 0, 1'b1);
      ack = 2'b01; tick(1); ack = '0;
      pin[0] = 1; tick(3);

      // constrained random against model
      tag = "R3/R4 random";
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(0, 3) == 0) pin[$urandom_range(0, 1)] ^= 1'b1;
         if ($urandom_range(0, 40) == 0) cfg[2*$urandom_range(0, 1) +: 2] = 2'($urandom_range(0, 3));
         mask   = ($urandom_range(0, 7) == 0) ? N'($urandom_range(0, 3)) : '1;
         gie    = ($urandom_range(0, 9) != 0);
         ack    = ($urandom_range(0, 5) == 0) ? N'($urandom_range(1, 3)) : '0;
         clr_wr = ($urandom_range(0, 9) == 0);
         clr_data = N'($urandom_range(0, 3));
         tick(1);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule